// File: doc/BRIEF.md
# I2C Start Condition Trigger Controller

This block decides when and how an I2C master puts a start or repeated-start condition on the bus. Software asks for a start with a one-cycle trigger write (`start_wr`). Depending on the bus status at that moment, the block does one of three things:

- It drives the start sequence at once.
- It keeps the request as a pending reservation until the bus goes free.
- It holds the request while this master is in a wait state and issues a repeated start when the wait ends.

The block drives only the SDA and SCL open-drain pull-down enables during the start sequence. The byte engine, acknowledge logic and stop generator around it report to it only through status inputs.

A start is made in two steps. SDA is pulled low first. SCL follows after a programmable hold count of system clocks. The cycle in which SCL is pulled low is marked by a one-cycle `start_done` pulse, and the block then hands both lines back to the surrounding controller.

A pending request is dropped in four cases:
- arbitration is lost;
- software commands an exit from communication;
- the interface is disabled;
- reset is asserted.

Illegal trigger writes are refused and reported with a one-cycle `req_rej` pulse.

Top module: `i2c_start_ctrl`

## Requirements
- R1: After an accepted trigger write with `bus_free`=1 and `wait_st`=0, `sda_oe` is 1 from the next cycle on. `scl_oe` goes to 1 exactly `hold_cnt`+1 cycles after `sda_oe` rose, and `sda_oe` stays 1 throughout.
- R2: `start_done` is 1 for exactly the one cycle in which `scl_oe` is 1. In the cycle after it, `sda_oe`, `scl_oe` and `pending` are all 0.
- R3: A trigger accepted while `bus_free`=0 and `wait_st`=0 leaves `pending`=1 with both enables at 0 until `bus_free` is seen at 1. From then on, the R1 sequence follows.
- R4: A trigger accepted while `wait_st`=1 keeps `pending`=1 with both enables at 0 until `wait_st` is seen at 0. A start sequence then follows without needing `bus_free`.
- R5: `arb_lost`=1 in a cycle returns the block to idle in the next cycle: `pending`=0 and both enables 0.
- R6: `exit_cmd`=1 in a cycle returns the block to idle in the next cycle.
- R7: `enable`=0 in a cycle returns the block to idle in the next cycle. Asserting `rst_n` low clears `pending` and both enables at once.
- R8: A trigger write in the same cycle as `stop_wr` is refused: `req_rej` is 1 in the next cycle and nothing else changes. A trigger write is also refused in the same way when `enable`, `exit_cmd` or `arb_lost` forbid it.
- R9: The trigger readback `trig_rd` is 0 in every cycle, including right after a write.
- R10: While `master_rx`=1, a trigger is accepted only if `wait_st`=1, `ack_en`=0 and `last_rx_done`=1 all hold. Otherwise it is refused as in R8.
- R11: A trigger write while `pending`=1 has no effect on the sequence and raises no `req_rej`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable |
| start_wr | input | 1 | One-cycle trigger write |
| stop_wr | input | 1 | One-cycle stop request write |
| exit_cmd | input | 1 | Exit from communication command |
| arb_lost | input | 1 | Arbitration lost flag |
| bus_free | input | 1 | Bus released (no master holds it) |
| wait_st | input | 1 | This master is in a wait state |
| master_rx | input | 1 | This master is receiving |
| ack_en | input | 1 | Acknowledge generation on |
| last_rx_done | input | 1 | Slave has been told the final byte arrived |
| hold_cnt | input | HOLD_W | Start hold time in clocks, minus one |
| sda_oe | output | 1 | Pull SDA low |
| scl_oe | output | 1 | Pull SCL low |
| pending | output | 1 | A start request is held or in progress |
| start_done | output | 1 | Start condition completed (one cycle) |
| req_rej | output | 1 | Trigger write refused (one cycle) |
| trig_rd | output | 1 | Trigger bit readback |

## Verification
The main function is exercised with three patterns, each telling apart one of the three start paths:
- Triggers on a free bus, which separate an immediate start from a reservation.
- Triggers on a busy bus released some cycles later, which show that the reservation waits and then fires.
- Triggers during a wait state, which show that a repeated start ignores `bus_free` and waits for the wait to end.

Collisions with `stop_wr`, and reception windows with each of the three gating bits wrong, separate refusal from acceptance. Clear inputs are applied mid-reservation and mid-hold. A seeded random phase then mixes all inputs and compares every output in every cycle with a bench model built from the requirements.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RESV = 3'd1,
    ST_WREL = 3'd2,
    ST_HOLD = 3'd3,
    ST_DONE = 3'd4
  } seq_st_e;
endpackage

// File: rtl/i2c_start_gate.sv
module i2c_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_wr,
  input  logic stop_wr,
  input  logic exit_cmd,
  input  logic arb_lost,
  input  logic wait_st,
  input  logic master_rx,
  input  logic ack_en,
  input  logic last_rx_done,
  output logic legal,
  output logic req_rej
);
  logic rx_ok;
  logic rej_d, rej_q;

  // During reception only the final-byte wait window admits a trigger
  always_comb begin
    rx_ok = !master_rx || (wait_st && !ack_en && last_rx_done);
    legal = enable && !stop_wr && !exit_cmd && !arb_lost && rx_ok;
    rej_d = start_wr && !legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rej_q <= 1'b0;
    else        rej_q <= rej_d;
  end

  assign req_rej = rej_q;

  p_stop_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && stop_wr) |=> req_rej);

  p_rx_ack_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && master_rx && ack_en) |=> req_rej);
endmodule

// File: rtl/i2c_start_timer.sv
module i2c_start_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              dec,
  input  logic [HOLD_W-1:0] load_val,
  output logic              zero
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load || (dec && (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  p_hold_countdown_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !zero) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
  import i2c_start_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic clear,
  input  logic bus_free,
  input  logic wait_st,
  input  logic tmr_zero,
  output logic tmr_load,
  output logic tmr_dec,
  output logic sda_oe,
  output logic scl_oe,
  output logic start_done,
  output logic pending
);
  seq_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clear) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
                   if (wait_st)       state_d = ST_WREL;
                   else if (bus_free) state_d = ST_HOLD;
                   else               state_d = ST_RESV;
                 end
        ST_RESV: if (bus_free) state_d = ST_HOLD;
        ST_WREL: if (!wait_st) state_d = ST_HOLD;
        ST_HOLD: if (tmr_zero) state_d = ST_DONE;
        ST_DONE: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    tmr_load   = (state_d == ST_HOLD) && (state_q != ST_HOLD);
    tmr_dec    = (state_q == ST_HOLD);
    sda_oe     = (state_q == ST_HOLD) || (state_q == ST_DONE);
    scl_oe     = (state_q == ST_DONE);
    start_done = (state_q == ST_DONE);
    pending    = (state_q != ST_IDLE);
  end

  p_done_after_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |-> $past(tmr_zero && state_q == ST_HOLD));

  p_resv_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESV && !bus_free && !clear) |=> (state_q == ST_RESV));

  p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WREL && wait_st && !clear) |=> (state_q == ST_WREL));
endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start_wr,
  input  logic              stop_wr,
  input  logic              exit_cmd,
  input  logic              arb_lost,
  input  logic              bus_free,
  input  logic              wait_st,
  input  logic              master_rx,
  input  logic              ack_en,
  input  logic              last_rx_done,
  input  logic [HOLD_W-1:0] hold_cnt,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              pending,
  output logic              start_done,
  output logic              req_rej,
  output logic              trig_rd
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       legal, accept, clear;
  logic       tmr_load, tmr_dec, tmr_zero;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_start_gate u_gate (
    .clk(clk), .rst_n(rst_int_n), .enable(enable), .start_wr(start_wr),
    .stop_wr(stop_wr), .exit_cmd(exit_cmd), .arb_lost(arb_lost),
    .wait_st(wait_st), .master_rx(master_rx), .ack_en(ack_en),
    .last_rx_done(last_rx_done), .legal(legal), .req_rej(req_rej)
  );

  always_comb begin
    accept = start_wr && legal;
    clear  = !enable || exit_cmd || arb_lost;
  end

  i2c_start_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .load(tmr_load), .dec(tmr_dec),
    .load_val(hold_cnt), .zero(tmr_zero)
  );

  i2c_start_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .accept(accept), .clear(clear),
    .bus_free(bus_free), .wait_st(wait_st), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_dec(tmr_dec), .sda_oe(sda_oe),
    .scl_oe(scl_oe), .start_done(start_done), .pending(pending)
  );

  // The trigger is an action, not a stored bit
  assign trig_rd = 1'b0;

  p_arb_clear_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    arb_lost |=> (!pending && !sda_oe && !scl_oe));

  p_exit_clear_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    exit_cmd |=> !pending);

  p_disable_clear_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !enable |=> !pending);

  p_rej_no_pend_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_wr && stop_wr && !pending) |=> !pending);
endmodule

// File: tb/i2c_start_ctrl_tb_top.sv
module i2c_start_ctrl_tb_top;
  localparam int HW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic enable, start_wr, stop_wr, exit_cmd, arb_lost, bus_free, wait_st;
  logic master_rx, ack_en, last_rx_done;
  logic [HW-1:0] hold_cnt;
  logic sda_oe, scl_oe, pending, start_done, req_rej, trig_rd;

  int n_chk = 0, n_bad = 0;
  int mph = 0;
  int mcnt = 0;
  bit mrej = 0;

  always #5 clk = ~clk;

  i2c_start_ctrl #(.HOLD_W(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_wr(start_wr),
    .stop_wr(stop_wr), .exit_cmd(exit_cmd), .arb_lost(arb_lost),
    .bus_free(bus_free), .wait_st(wait_st), .master_rx(master_rx),
    .ack_en(ack_en), .last_rx_done(last_rx_done), .hold_cnt(hold_cnt),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .pending(pending),
    .start_done(start_done), .req_rej(req_rej), .trig_rd(trig_rd)
  );

  function automatic bit legal_f();
    return enable && !stop_wr && !exit_cmd && !arb_lost &&
           (!master_rx || (wait_st && !ack_en && last_rx_done));
  endfunction

  // Requirement model: 0 idle, 1 reserved, 2 wait release, 3 hold, 4 done
  task automatic model_step();
    mrej = start_wr && !legal_f();
    if (!enable || exit_cmd || arb_lost) mph = 0;
    else case (mph)
      0: if (start_wr && legal_f()) begin
           if (wait_st) mph = 2;
           else if (bus_free) begin mph = 3; mcnt = int'(hold_cnt); end
           else mph = 1;
         end
      1: if (bus_free) begin mph = 3; mcnt = int'(hold_cnt); end
      2: if (!wait_st) begin mph = 3; mcnt = int'(hold_cnt); end
      3: if (mcnt == 0) mph = 4; else mcnt--;
      default: mph = 0;
    endcase
  endtask

  task automatic chk(string tag, bit act, bit exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic cmp(string tag);
    n_chk++;
    if (sda_oe !== (mph == 3 || mph == 4) || scl_oe !== (mph == 4) ||
        start_done !== (mph == 4) || pending !== (mph != 0) ||
        req_rej !== mrej || trig_rd !== 1'b0) begin
      n_bad++;
      $display("FAIL %s outputs sda/scl/done/pend/rej/rd actual=%b%b%b%b%b%b expected=%b%b%b%b%b0",
               tag, sda_oe, scl_oe, start_done, pending, req_rej, trig_rd,
               (mph == 3 || mph == 4), (mph == 4), (mph == 4), (mph != 0), mrej);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic quiet();
    enable = 1; start_wr = 0; stop_wr = 0; exit_cmd = 0; arb_lost = 0;
    bus_free = 1; wait_st = 0; master_rx = 0; ack_en = 0; last_rx_done = 0;
  endtask

  task automatic trig_once(string tag);
    start_wr = 1; cyc(tag); start_wr = 0;
  endtask

  initial begin
    #1_900_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n;
    quiet(); hold_cnt = 8'd3; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R7 reset", pending, 1'b0, "pending");
    chk("R7 reset", sda_oe, 1'b0, "sda_oe");
    rst_n = 1;
    repeat (4) cyc("R7 post-reset");

    // R1 / R2 / R9: immediate start, hold 3
    trig_once("R9 readback");
    chk("R9", trig_rd, 1'b0, "trig_rd");
    n = 0;
    while (!scl_oe && n < 20) begin
      if (sda_oe) n++;
      cyc("R1 hold");
    end
    chk("R1 scl delay", n == 4, 1'b1, "hold+1 cycles");
    chk("R2 done", start_done, 1'b1, "start_done");
    cyc("R2 release");
    chk("R2 release", pending, 1'b0, "pending");

    // R1 with hold 0
    hold_cnt = 0; trig_once("R1 hold0"); repeat (3) cyc("R1 hold0");

    // R3 reservation
    hold_cnt = 2; bus_free = 0; trig_once("R3 reserve");
    repeat (6) cyc("R3 waiting");
    chk("R3 held", pending, 1'b1, "pending");
    chk("R3 held", sda_oe, 1'b0, "sda_oe");
    bus_free = 1; repeat (6) cyc("R3 fire");

    // R4 repeated start after wait, bus not free
    bus_free = 0; wait_st = 1; trig_once("R4 wait");
    repeat (4) cyc("R4 waiting");
    wait_st = 0; repeat (6) cyc("R4 restart");
    chk("R4 done", pending, 1'b0, "pending");
    bus_free = 1;

    // R11 write while pending
    hold_cnt = 4; trig_once("R11 first");
    start_wr = 1; cyc("R11 second"); start_wr = 0;
    chk("R11 no rej", req_rej, 1'b0, "req_rej");
    repeat (6) cyc("R11 finish");

    // R5 / R6 / R7 clears
    bus_free = 0; trig_once("R5 setup"); arb_lost = 1; cyc("R5 arb"); arb_lost = 0;
    chk("R5", pending, 1'b0, "pending");
    bus_free = 1; hold_cnt = 5; trig_once("R6 setup"); cyc("R6 mid");
    exit_cmd = 1; cyc("R6 exit"); exit_cmd = 0;
    chk("R6", sda_oe, 1'b0, "sda_oe");
    bus_free = 0; trig_once("R7 setup"); enable = 0; cyc("R7 dis"); enable = 1;
    chk("R7", pending, 1'b0, "pending");
    bus_free = 1;
    trig_once("R7 async setup");
    rst_n = 0; #1;
    chk("R7 async", sda_oe, 1'b0, "sda_oe");
    mph = 0; mrej = 0;
    @(negedge clk); rst_n = 1; repeat (4) cyc("R7 recover");

    // R8 stop collision
    start_wr = 1; stop_wr = 1; cyc("R8 collide"); start_wr = 0; stop_wr = 0;
    chk("R8 rej", req_rej, 1'b1, "req_rej");
    chk("R8 none", pending, 1'b0, "pending");
    cyc("R8 after");

    // R10 reception gating
    master_rx = 1; wait_st = 1; ack_en = 1; last_rx_done = 1;
    trig_once("R10 ack on"); chk("R10 ackon", req_rej, 1'b1, "req_rej");
    ack_en = 0; last_rx_done = 0;
    trig_once("R10 not last"); chk("R10 notlast", req_rej, 1'b1, "req_rej");
    last_rx_done = 1; wait_st = 0;
    trig_once("R10 no wait"); chk("R10 nowait", req_rej, 1'b1, "req_rej");
    wait_st = 1;
    trig_once("R10 ok"); chk("R10 ok", pending, 1'b1, "pending");
    wait_st = 0; master_rx = 0; repeat (8) cyc("R10 finish");

    // Random mix
    void'($urandom(32'd4711));
    for (int i = 0; i < 3000; i++) begin
      start_wr     = ($urandom % 100) < 20;
      stop_wr      = ($urandom % 100) < 5;
      exit_cmd     = ($urandom % 100) < 3;
      arb_lost     = ($urandom % 100) < 3;
      enable       = ($urandom % 100) < 96;
      bus_free     = ($urandom % 100) < 55;
      wait_st      = ($urandom % 100) < 30;
      master_rx    = ($urandom % 100) < 30;
      ack_en       = ($urandom % 2) == 1;
      last_rx_done = ($urandom % 2) == 1;
      hold_cnt     = HW'($urandom % 6);
      cyc("R1-mix random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule